// File: doc/BRIEF.md
# Destination MAC Address Filter

This block decides, for every received frame, whether the frame goes up to the CPU or is discarded. The receive path presents the 48-bit destination address with a one-cycle strobe. One clock later the block returns a registered decision. The decision has a forward flag, a hit flag, and the index of the filter entry that matched.

The decision combines several sources:
- a bank of perfect-match entries, each of which can be enabled and can be allowed to forward;
- the host's own station address;
- pass-through bits per address class (unicast, multicast, broadcast);
- a promiscuous override.

A global forwarding enable gates everything. By convention, entries 0 and 1 hold unicast addresses and entries 2 to 7 hold multicast addresses. The hardware treats all entries alike.

Software programs the block through a small word-addressed register port. A write completes in one cycle. Reads are combinational from the same address bus.

Top module: `addr_filter`

## Requirements
- R1: After reset every register reads zero, `dec_valid_o`, `fwd_o` and `hit_o` are low, and any frame is dropped.
- R2: A strobe on `dst_valid_i` produces `dec_valid_o` high in the following cycle only. When `dec_valid_o` is low, `fwd_o`, `hit_o` and `hit_idx_o` are zero.
- R3: When bit 5 of the forwarding register (offset 0x000) is clear, every frame is dropped, including in promiscuous mode.
- R4: When bit 5 and bit 7 (promiscuous) of the forwarding register are both set, every frame is forwarded.
- R5: The class register (offset 0x004) has three pass bits:
  - bit 1 forwards unicast frames (address bit 40 clear);
  - bit 3 forwards multicast frames (bit 40 set and the address not all ones);
  - bit 5 forwards broadcast frames (all 48 bits one).
- R6: When bit 7 of the class register (filter enable) is clear, neither the host address nor any entry matches, so `hit_o` stays low.
- R7: The host address is held in two registers: bits 31:0 at offset 0x008, and bits 47:32 in bits 15:0 of offset 0x00C. With the filter enabled, a frame carrying that address is forwarded.
- R8: Each entry n has two words:
  - the low word at 0x100+8n holds address bits 31:0;
  - the high word at 0x104+8n holds address bits 47:32 in bits 15:0, the enable in bit 17 and the forward-to-CPU bit in bit 21.

  An enabled entry that matches raises `hit_o` with its index. The frame is forwarded if any enabled matching entry has forward-to-CPU set.
- R9: An entry whose enable bit is clear never matches.
- R10: When several enabled entries match, `hit_idx_o` reports the lowest-numbered one.
- R11: Reads return the defined bits of the addressed register and zero elsewhere. Unmapped addresses read zero, and writes to them have no effect.
- R12: A register write affects strobes from the next cycle on. A strobe in the same cycle as the write is decided with the previous register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Byte address for both read and write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| dst_valid_i | input | 1 | Destination address valid strobe |
| dst_addr_i | input | 48 | Destination address; the first byte on the wire is bits 47:40 |
| dec_valid_o | output | 1 | Decision valid, one cycle after the strobe |
| fwd_o | output | 1 | Forward the frame to the CPU |
| hit_o | output | 1 | An enabled filter entry matched |
| hit_idx_o | output | 3 | Lowest matching entry index |

## Verification
Random configurations of the control, class, host and entry registers are each probed with five kinds of address:
- an address copied from an entry, which separates enabled from disabled entries and exercises the forward-to-CPU bit;
- the host address, which isolates the host match;
- the all-ones broadcast address, which separates the broadcast class from multicast;
- a random address with random group bit, which exercises the unicast and multicast pass bits;
- an entry address with one bit flipped, which shows that matching is exact and not partial.

Directed cases load the same address into several entries to expose priority. They also put a register write and a strobe in the same cycle, to pin down when a write takes effect.

// File: rtl/addr_filter_pkg.sv
package addr_filter_pkg;
  localparam int unsigned MAC_W  = 48;
  localparam int unsigned REG_AW = 12;
  localparam int unsigned REG_DW = 32;

  localparam int unsigned OFS_FWD      = 'h000;
  localparam int unsigned OFS_CLASS    = 'h004;
  localparam int unsigned OFS_HOST_LO  = 'h008;
  localparam int unsigned OFS_HOST_HI  = 'h00C;
  localparam int unsigned ENTRY_BASE   = 'h100;
  localparam int unsigned ENTRY_STRIDE = 8;

  localparam int unsigned FWD_EN_BIT  = 5;
  localparam int unsigned PROMISC_BIT = 7;
  localparam int unsigned UC_PASS_BIT = 1;
  localparam int unsigned MC_PASS_BIT = 3;
  localparam int unsigned BC_PASS_BIT = 5;
  localparam int unsigned FILT_EN_BIT = 7;
  localparam int unsigned ENT_EN_BIT  = 17;
  localparam int unsigned ENT_FWD_BIT = 21;

  // group bit: bit 0 of the first address byte
  localparam int unsigned GROUP_BIT = MAC_W - 8;

  typedef struct packed {
    logic [MAC_W-1:0] mac;
    logic             en;
    logic             fwd;
  } entry_t;

  typedef struct packed {
    logic fwd_en;
    logic promisc;
    logic uc_pass;
    logic mc_pass;
    logic bc_pass;
    logic filt_en;
  } ctrl_t;
endpackage

// File: rtl/addr_filter_regs.sv
module addr_filter_regs
  import addr_filter_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [REG_AW-1:0]             addr_i,
  input  logic [REG_DW-1:0]             wdata_i,
  output logic [REG_DW-1:0]             rdata_o,
  output ctrl_t                         ctrl_o,
  output logic [MAC_W-1:0]              host_o,
  output entry_t [NUM_ENTRIES-1:0]      entries_o
);
  localparam int unsigned HI_W = MAC_W - 32;

  ctrl_t            ctrl_q;
  logic [MAC_W-1:0] host_q;
  entry_t [NUM_ENTRIES-1:0] entry_q;

  logic sel_fwd, sel_class, sel_hlo, sel_hhi;
  assign sel_fwd   = addr_i == REG_AW'(OFS_FWD);
  assign sel_class = addr_i == REG_AW'(OFS_CLASS);
  assign sel_hlo   = addr_i == REG_AW'(OFS_HOST_LO);
  assign sel_hhi   = addr_i == REG_AW'(OFS_HOST_HI);

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[REG_DW-1:ENT_FWD_BIT+1], wdata_i[ENT_FWD_BIT-1:ENT_EN_BIT+1],
                          wdata_i[ENT_EN_BIT-1:HI_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      host_q <= '0;
    end else if (we_i) begin
      if (sel_fwd) begin
        ctrl_q.fwd_en  <= wdata_i[FWD_EN_BIT];
        ctrl_q.promisc <= wdata_i[PROMISC_BIT];
      end
      if (sel_class) begin
        ctrl_q.uc_pass <= wdata_i[UC_PASS_BIT];
        ctrl_q.mc_pass <= wdata_i[MC_PASS_BIT];
        ctrl_q.bc_pass <= wdata_i[BC_PASS_BIT];
        ctrl_q.filt_en <= wdata_i[FILT_EN_BIT];
      end
      if (sel_hlo) host_q[31:0]    <= wdata_i;
      if (sel_hhi) host_q[MAC_W-1:32] <= wdata_i[HI_W-1:0];
    end
  end

  for (genvar n = 0; n < NUM_ENTRIES; n++) begin : g_entry
    localparam int unsigned LO_OFS = ENTRY_BASE + ENTRY_STRIDE * n;
    logic sel_lo, sel_hi;
    assign sel_lo = we_i && (addr_i == REG_AW'(LO_OFS));
    assign sel_hi = we_i && (addr_i == REG_AW'(LO_OFS + 4));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        entry_q[n] <= '0;
      end else begin
        if (sel_lo) entry_q[n].mac[31:0] <= wdata_i;
        if (sel_hi) begin
          entry_q[n].mac[MAC_W-1:32] <= wdata_i[HI_W-1:0];
          entry_q[n].en              <= wdata_i[ENT_EN_BIT];
          entry_q[n].fwd             <= wdata_i[ENT_FWD_BIT];
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_fwd) begin
      rdata_o[FWD_EN_BIT]  = ctrl_q.fwd_en;
      rdata_o[PROMISC_BIT] = ctrl_q.promisc;
    end
    if (sel_class) begin
      rdata_o[UC_PASS_BIT] = ctrl_q.uc_pass;
      rdata_o[MC_PASS_BIT] = ctrl_q.mc_pass;
      rdata_o[BC_PASS_BIT] = ctrl_q.bc_pass;
      rdata_o[FILT_EN_BIT] = ctrl_q.filt_en;
    end
    if (sel_hlo) rdata_o = host_q[31:0];
    if (sel_hhi) rdata_o[HI_W-1:0] = host_q[MAC_W-1:32];
    for (int n = 0; n < NUM_ENTRIES; n++) begin
      if (addr_i == REG_AW'(ENTRY_BASE + ENTRY_STRIDE * n))
        rdata_o = entry_q[n].mac[31:0];
      if (addr_i == REG_AW'(ENTRY_BASE + ENTRY_STRIDE * n + 4)) begin
        rdata_o[HI_W-1:0]   = entry_q[n].mac[MAC_W-1:32];
        rdata_o[ENT_EN_BIT]  = entry_q[n].en;
        rdata_o[ENT_FWD_BIT] = entry_q[n].fwd;
      end
    end
  end

  assign ctrl_o    = ctrl_q;
  assign host_o    = host_q;
  assign entries_o = entry_q;
endmodule

// File: rtl/addr_filter_match.sv
module addr_filter_match
  import addr_filter_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 8,
  localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic [MAC_W-1:0]         mac_i,
  input  logic                     filt_en_i,
  input  entry_t [NUM_ENTRIES-1:0] entries_i,
  output logic                     hit_o,
  output logic [IDX_W-1:0]         idx_o,
  output logic                     fwd_o
);
  logic [NUM_ENTRIES-1:0] match_vec;
  logic [NUM_ENTRIES-1:0] fwd_vec;

  for (genvar n = 0; n < NUM_ENTRIES; n++) begin : g_cmp
    assign match_vec[n] = filt_en_i && entries_i[n].en && (entries_i[n].mac == mac_i);
    assign fwd_vec[n]   = entries_i[n].fwd;
  end

  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int n = NUM_ENTRIES - 1; n >= 0; n--) begin
      if (match_vec[n]) idx_o = IDX_W'(n);
    end
  end

  assign hit_o = |match_vec;
  assign fwd_o = |(match_vec & fwd_vec);
endmodule

// File: rtl/addr_filter_decide.sv
module addr_filter_decide
  import addr_filter_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [MAC_W-1:0] mac_i,
  input  ctrl_t            ctrl_i,
  input  logic [MAC_W-1:0] host_i,
  input  logic             ent_hit_i,
  input  logic [IDX_W-1:0] ent_idx_i,
  input  logic             ent_fwd_i,
  output logic             dec_valid_o,
  output logic             fwd_o,
  output logic             hit_o,
  output logic [IDX_W-1:0] hit_idx_o
);
  logic is_mc, is_bc, class_pass, host_hit, fwd_d;

  assign is_mc      = mac_i[GROUP_BIT];
  assign is_bc      = &mac_i;
  assign class_pass = (is_bc && ctrl_i.bc_pass) ||
                      (is_mc && !is_bc && ctrl_i.mc_pass) ||
                      (!is_mc && ctrl_i.uc_pass);
  assign host_hit   = ctrl_i.filt_en && (mac_i == host_i);
  assign fwd_d      = ctrl_i.fwd_en &&
                      (ctrl_i.promisc || class_pass || host_hit || ent_fwd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o <= 1'b0;
      fwd_o       <= 1'b0;
      hit_o       <= 1'b0;
      hit_idx_o   <= '0;
    end else begin
      dec_valid_o <= valid_i;
      fwd_o       <= valid_i && fwd_d;
      hit_o       <= valid_i && ent_hit_i;
      hit_idx_o   <= (valid_i && ent_hit_i) ? ent_idx_i : '0;
    end
  end
endmodule

// File: rtl/addr_filter.sv
module addr_filter
  import addr_filter_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 8,
  localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  input  logic              dst_valid_i,
  input  logic [MAC_W-1:0]  dst_addr_i,
  output logic              dec_valid_o,
  output logic              fwd_o,
  output logic              hit_o,
  output logic [IDX_W-1:0]  hit_idx_o
);
  ctrl_t                    ctrl_q;
  logic [MAC_W-1:0]         host_q;
  entry_t [NUM_ENTRIES-1:0] entry_q;
  logic                     ent_hit, ent_fwd;
  logic [IDX_W-1:0]         ent_idx;

  addr_filter_regs #(.NUM_ENTRIES(NUM_ENTRIES)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .ctrl_o    (ctrl_q),
    .host_o    (host_q),
    .entries_o (entry_q)
  );

  addr_filter_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
    .mac_i     (dst_addr_i),
    .filt_en_i (ctrl_q.filt_en),
    .entries_i (entry_q),
    .hit_o     (ent_hit),
    .idx_o     (ent_idx),
    .fwd_o     (ent_fwd)
  );

  addr_filter_decide #(.IDX_W(IDX_W)) u_decide (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (dst_valid_i),
    .mac_i       (dst_addr_i),
    .ctrl_i      (ctrl_q),
    .host_i      (host_q),
    .ent_hit_i   (ent_hit),
    .ent_idx_i   (ent_idx),
    .ent_fwd_i   (ent_fwd),
    .dec_valid_o (dec_valid_o),
    .fwd_o       (fwd_o),
    .hit_o       (hit_o),
    .hit_idx_o   (hit_idx_o)
  );
endmodule

// File: rtl/addr_filter_chk.sv
module addr_filter_chk #(
  parameter int unsigned IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dst_valid_i,
  input logic             dec_valid_o,
  input logic             fwd_o,
  input logic             hit_o,
  input logic [IDX_W-1:0] hit_idx_o,
  input logic             fwd_en_i,
  input logic             promisc_i,
  input logic             filt_en_i
);
  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_valid_i |=> dec_valid_o);
  a_r2_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dst_valid_i |=> !dec_valid_o);
  a_r2_quiet_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_o |-> (!fwd_o && !hit_o && hit_idx_o == '0));
  a_r3_fwd_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_valid_i && !fwd_en_i) |=> !fwd_o);
  a_r4_promisc_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_valid_i && fwd_en_i && promisc_i) |=> fwd_o);
  a_r6_filter_off_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_valid_i && !filt_en_i) |=> !hit_o);
endmodule

bind addr_filter addr_filter_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dst_valid_i (dst_valid_i),
  .dec_valid_o (dec_valid_o),
  .fwd_o       (fwd_o),
  .hit_o       (hit_o),
  .hit_idx_o   (hit_idx_o),
  .fwd_en_i    (ctrl_q.fwd_en),
  .promisc_i   (ctrl_q.promisc),
  .filt_en_i   (ctrl_q.filt_en)
);

// File: tb/addr_filter_test.sv
module addr_filter_test;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dst_valid = 1'b0;
  logic [47:0] dst_addr = '0;
  logic        dec_valid, fwd, hit;
  logic [2:0]  hit_idx;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_filter uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .dst_valid_i(dst_valid),
    .dst_addr_i(dst_addr), .dec_valid_o(dec_valid), .fwd_o(fwd), .hit_o(hit),
    .hit_idx_o(hit_idx)
  );

  // shadow model of register state
  logic [47:0] s_mac [NE];
  logic        s_en  [NE];
  logic        s_fw  [NE];
  logic [47:0] s_host;
  logic s_fwd_en, s_prom, s_uc, s_mc, s_bc, s_filt;

  task automatic chk(string req, logic [47:0] act, logic [47:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int n = 0; n < NE; n++) begin s_mac[n] = '0; s_en[n] = 0; s_fw[n] = 0; end
    s_host = '0;
    {s_fwd_en, s_prom, s_uc, s_mc, s_bc, s_filt} = '0;
  endtask

  task automatic model_write(logic [11:0] a, logic [31:0] d);
    if (a == 12'h000) begin s_fwd_en = d[5]; s_prom = d[7]; end
    else if (a == 12'h004) begin s_uc = d[1]; s_mc = d[3]; s_bc = d[5]; s_filt = d[7]; end
    else if (a == 12'h008) s_host[31:0] = d;
    else if (a == 12'h00C) s_host[47:32] = d[15:0];
    else for (int n = 0; n < NE; n++) begin
      if (a == 12'(256 + 8*n)) s_mac[n][31:0] = d;
      if (a == 12'(260 + 8*n)) begin
        s_mac[n][47:32] = d[15:0]; s_en[n] = d[17]; s_fw[n] = d[21];
      end
    end
  endtask

  function automatic logic [31:0] exp_read(logic [11:0] a);
    logic [31:0] r = '0;
    if (a == 12'h000) begin r[5] = s_fwd_en; r[7] = s_prom; end
    else if (a == 12'h004) begin r[1] = s_uc; r[3] = s_mc; r[5] = s_bc; r[7] = s_filt; end
    else if (a == 12'h008) r = s_host[31:0];
    else if (a == 12'h00C) r[15:0] = s_host[47:32];
    else for (int n = 0; n < NE; n++) begin
      if (a == 12'(256 + 8*n)) r = s_mac[n][31:0];
      if (a == 12'(260 + 8*n)) begin r[15:0] = s_mac[n][47:32]; r[17] = s_en[n]; r[21] = s_fw[n]; end
    end
    return r;
  endfunction

  // {fwd, hit, idx}
  function automatic logic [4:0] exp_dec(logic [47:0] m);
    logic mc = m[40];
    logic bc = &m;
    logic cls = (bc && s_bc) || (mc && !bc && s_mc) || (!mc && s_uc);
    logic hh = s_filt && (m == s_host);
    logic h = 0, ef = 0;
    logic [2:0] ix = '0;
    for (int n = NE - 1; n >= 0; n--) begin
      if (s_filt && s_en[n] && s_mac[n] == m) begin
        h = 1; ix = 3'(n);
        if (s_fw[n]) ef = 1;
      end
    end
    return {s_fwd_en && (s_prom || cls || hh || ef), h, ix};
  endfunction

  // all tasks start and end just after a falling edge
  task automatic wr(logic [11:0] a, logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    model_write(a, d);
  endtask

  task automatic rd(logic [11:0] a, string req);
    reg_addr = a;
    #1;
    chk(req, 48'(reg_rdata), 48'(exp_read(a)), $sformatf("read 0x%03h", a));
  endtask

  task automatic probe(logic [47:0] m, string req);
    logic [4:0] e = exp_dec(m);
    dst_valid = 1; dst_addr = m;
    @(negedge clk);
    dst_valid = 0;
    chk(req, 48'(dec_valid), 48'(1), "dec_valid");
    chk(req, 48'(fwd), 48'(e[4]), $sformatf("fwd for %h", m));
    chk(req, 48'(hit), 48'(e[3]), $sformatf("hit for %h", m));
    chk(req, 48'(hit_idx), 48'(e[2:0]), $sformatf("idx for %h", m));
  endtask

  function automatic logic [31:0] hi_word(logic [47:0] m, logic en, logic fw);
    logic [31:0] w = '0;
    w[15:0] = m[47:32]; w[17] = en; w[21] = fw;
    return w;
  endfunction

  task automatic set_entry(int n, logic [47:0] m, logic en, logic fw);
    wr(12'(256 + 8*n), m[31:0]);
    wr(12'(260 + 8*n), hi_word(m, en, fw));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [47:0] m_a, m_b, ucm;
    logic [4:0] e;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1", 48'(dec_valid), 48'(0), "dec_valid after reset");
    chk("R1", 48'({fwd, hit}), 48'(0), "fwd/hit after reset");
    rd(12'h000, "R1"); rd(12'h004, "R1"); rd(12'h00C, "R1"); rd(12'h104, "R1");
    probe('1, "R1");

    // R3 forwarding disabled overrides class and promiscuous
    wr(12'h004, 32'h0000_002A);
    wr(12'h000, 32'h0000_0080);
    probe('1, "R3");
    probe(48'h0200_1111_2222, "R3");

    // R5 class pass bits, one at a time
    wr(12'h000, 32'h0000_0020);
    wr(12'h004, 32'h0000_0020);
    probe('1, "R5");
    probe(48'h0100_5E00_0001, "R5");
    probe(48'h0024_8100_7777, "R5");
    wr(12'h004, 32'h0000_0008);
    probe('1, "R5");
    probe(48'h0100_5E00_0001, "R5");
    wr(12'h004, 32'h0000_0002);
    probe(48'h0024_8100_7777, "R5");
    probe(48'h0100_5E00_0001, "R5");

    // R4 promiscuous
    wr(12'h004, 32'h0000_0000);
    wr(12'h000, 32'h0000_00A0);
    probe(48'h0024_8100_7777, "R4");
    probe(48'h0300_0000_0009, "R4");
    wr(12'h000, 32'h0000_0020);

    // R6 / R7 host address
    ucm = 48'h0012_3456_789A;
    wr(12'h008, ucm[31:0]);
    wr(12'h00C, {16'hFFFF, ucm[47:32]});
    rd(12'h00C, "R11");
    set_entry(0, ucm, 1'b1, 1'b1);
    probe(ucm, "R6");
    wr(12'h004, 32'h0000_0080);
    probe(ucm, "R7");
    set_entry(0, '0, 1'b0, 1'b0);
    probe(ucm, "R7");

    // R8 / R10 / R9 entries
    m_a = 48'h0100_5E7F_0042;
    m_b = 48'h0100_5E7F_0043;
    set_entry(3, m_a, 1'b1, 1'b0);
    set_entry(5, m_a, 1'b1, 1'b1);
    set_entry(6, m_b, 1'b0, 1'b1);
    probe(m_a, "R10");
    probe(m_b, "R9");
    rd(12'h11C, "R8"); rd(12'h118, "R8"); rd(12'h134, "R8");
    set_entry(5, m_a, 1'b1, 1'b0);
    probe(m_a, "R8");
    set_entry(3, m_a, 1'b0, 1'b0);
    set_entry(5, m_a, 1'b1, 1'b1);
    probe(m_a, "R10");

    // R2 idle cycle after a decision
    @(negedge clk);
    chk("R2", 48'(dec_valid), 48'(0), "dec_valid idle");
    chk("R2", 48'({fwd, hit, hit_idx}), 48'(0), "outputs idle");

    // R11 unmapped access
    wr(12'h0FC, 32'hFFFF_FFFF);
    wr(12'h010, 32'hFFFF_FFFF);
    rd(12'h0FC, "R11"); rd(12'h010, "R11"); rd(12'h000, "R11"); rd(12'h004, "R11");
    probe(48'h0024_8100_7777, "R11");

    // R12 write and strobe in the same cycle
    e = exp_dec(m_b);
    reg_we = 1; reg_addr = 12'h134; reg_wdata = hi_word(m_b, 1'b1, 1'b1);
    dst_valid = 1; dst_addr = m_b;
    @(negedge clk);
    reg_we = 0; dst_valid = 0;
    model_write(12'h134, hi_word(m_b, 1'b1, 1'b1));
    chk("R12", 48'({fwd, hit, hit_idx}), 48'(e), "same-cycle decision uses old state");
    probe(m_b, "R12");

    // randomized mix
    for (int it = 0; it < 600; it++) begin
      int sel = $urandom_range(0, 9);
      logic [47:0] m;
      int n;
      if (sel == 0) wr(12'h000, $urandom);
      else if (sel == 1) wr(12'h004, $urandom);
      else if (sel == 2) begin
        n = $urandom_range(0, NE - 1);
        m = {$urandom, $urandom};
        set_entry(n, m, 1'($urandom_range(0, 3) != 0), 1'($urandom));
      end else if (sel == 3) wr(12'(256 + 8 * $urandom_range(0, 63)), $urandom);
      if ($urandom_range(0, 30) == 0) begin
        wr(12'h008, $urandom); wr(12'h00C, $urandom);
      end
      case ($urandom_range(0, 4))
        0: m = s_mac[$urandom_range(0, NE - 1)];
        1: m = s_host;
        2: m = '1;
        3: m = {$urandom, $urandom};
        default: begin
          m = s_mac[$urandom_range(0, NE - 1)];
          m[$urandom_range(0, 47)] ^= 1'b1;
        end
      endcase
      probe(m, "R8");
      if ($urandom_range(0, 7) == 0) rd(12'(4 * $urandom_range(0, 127)), "R11");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule